// File: doc/BRIEF.md
# Framed Serial Receiver with Idle Timeout

This block receives an asynchronous-style framed byte stream that is clocked by an external receive-timing signal. Each bit is taken on one selected edge of that timing signal. Once enabled, the receiver first waits for a run of idle (marking) bits. After that it accepts frames made of one start bit, eight data bits and one parity bit. Received bytes are checked for parity and packed into 32-bit words, which enter a word FIFO that the surrounding logic drains.

Packets have no explicit length on the line. A packet ends when the line stays idle for a programmed number of bit times after the last parity bit. At that point any partly filled word is written to the word FIFO with its unused byte lanes zeroed, and the packet's byte count is written to a separate length FIFO. A parity mismatch sets a sticky parity-error flag, which can drive an interrupt output. A word that arrives while the word FIFO is full is dropped and sets a sticky overflow flag. Both flags are cleared by write-one pulses.

Top module: `framed_rx`

## Requirements
- R1: After reset the word FIFO and the length FIFO are empty (wordEmpty=1, lenEmpty=1, wordCount=0), and ovfFlag, parErrFlag and parIrq are 0.
- R2: After rxEn rises, no start bit is recognised until at least 10 consecutive marking samples (rxData equal to markLevel) have been taken. A non-marking sample restarts that run.
- R3: rxData is sampled once per rising edge of rxTiming when clkPol=0, and once per falling edge when clkPol=1.
- R4: A frame is a start bit at level ~markLevel, then 8 data bits, then 1 parity bit. With msbFirst=0 the first data bit lands in bit 0 of the byte. With msbFirst=1 it lands in bit 7.
- R5: The expected parity bit is the XOR of the 8 data bits, inverted when oddParity=1. A mismatch sets parErrFlag, which stays set until a clrParErr pulse. parIrq is high while parErrFlag and parIntEn are both 1. The byte is stored even when its parity is wrong.
- R6: Bytes are packed four to a word. With hiByteFirst=0 the first byte of a word occupies bits 7:0. With hiByteFirst=1 it occupies bits 31:24.
- R7: With toLen=N (N≥1), a packet ends on the N-th marking sample taken after its last parity bit. A start bit that arrives after N-1 or fewer idle samples continues the same packet.
- R8: When a packet ends, a partly filled word is pushed with its unused lanes zero, and the packet's byte count is pushed to the length FIFO (read at lenData).
- R9: wordCount reports the number of words held in the word FIFO (depth 4 by default). wordData shows the oldest word, and wordRdEn removes it.
- R10: A word pushed while the word FIFO is full is dropped and sets ovfFlag. ovfFlag stays set until a clrOvf pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low reset |
| rxEn | input | 1 | Receiver enable; low discards any partial packet and disarms |
| markLevel | input | 1 | Idle/stop line level; the start bit is its complement |
| clkPol | input | 1 | 0: sample on rising rxTiming, 1: on falling |
| msbFirst | input | 1 | Bit order of the data bits on the line |
| hiByteFirst | input | 1 | Byte lane order inside a word |
| oddParity | input | 1 | Parity sense: 0 even, 1 odd |
| parIntEn | input | 1 | Enables parIrq from parErrFlag |
| toLen | input | 16 | Idle timeout length in bit samples |
| rxTiming | input | 1 | Receive timing line |
| rxData | input | 1 | Receive data line |
| wordRdEn | input | 1 | Pops the word FIFO |
| wordData | output | 32 | Oldest word in the word FIFO |
| wordEmpty | output | 1 | Word FIFO empty |
| wordCount | output | 3 | Words held in the word FIFO |
| lenRdEn | input | 1 | Pops the length FIFO |
| lenData | output | 16 | Oldest packet byte count |
| lenEmpty | output | 1 | Length FIFO empty |
| clrOvf | input | 1 | Write-one clear of ovfFlag |
| ovfFlag | output | 1 | Sticky word FIFO overflow |
| clrParErr | input | 1 | Write-one clear of parErrFlag |
| parErrFlag | output | 1 | Sticky parity error |
| parIrq | output | 1 | Parity error interrupt |

## Verification
A vector table sends complete packets of one, three and four bytes. Each packet uses a different mix of bit order, byte lane order and parity sense. The set is built so that a swapped lane, a reversed bit order or a wrong parity sense each produce a distinct word. Directed patterns then probe the edges of the block's behaviour:
- a nine-bit marking run followed by an all-ones frame, which must be ignored;
- idle gaps of N-1 and N samples, which separate a continued packet from a closed one;
- a frame with a deliberately wrong parity bit;
- twenty back-to-back bytes, which overrun the word FIFO;
- frames sent with inverted clock polarity and with inverted marking level, which fail if the wrong edge or the wrong start level is used.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef struct packed {
    logic shiftEn;  // take one data bit
    logic parChk;   // parity bit sample: check and store byte
    logic flush;    // idle timeout: close packet
    logic drop;     // receiver disabled: discard partial state
  } rxStrb_t;

  typedef enum logic [1:0] {ST_ARM, ST_HUNT, ST_DATA, ST_PAR} rxState_t;
endpackage

// File: rtl/rxf_fifo.sv
module rxf_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic [W-1:0] popData,
  output logic         empty,
  output logic         full,
  output logic [$clog2(DEPTH):0] count
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;
  logic         doPush, doPop;

  assign empty  = (wp == rp);
  assign full   = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign popData = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (doPush) mem[wp[AW-1:0]] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
    end else begin
      if (doPush) wp <= wp + 1'b1;
      if (doPop)  rp <= rp + 1'b1;
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
#(
  parameter int ARM_RUN = 10,
  parameter int TO_W    = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            rxEn,
  input  logic            markLevel,
  input  logic            clkPol,
  input  logic            rxTiming,
  input  logic            rxData,
  input  logic [TO_W-1:0] toLen,
  output rxStrb_t         strb
);
  localparam int RUN_W = $clog2(ARM_RUN + 1);

  rxState_t        state;
  logic            prevT;
  logic [RUN_W-1:0] runCnt;
  logic [2:0]      bitCnt;
  logic [TO_W-1:0] toCnt;
  logic            pktOpen;
  logic            tick, isMark, toHit;

  // one sample per selected edge of the timing line
  assign tick   = rxEn && (prevT == clkPol) && (rxTiming != clkPol);
  assign isMark = (rxData == markLevel);
  // idle counter starts at zero; the packet closes on the toLen-th idle sample
  assign toHit  = ({1'b0, toCnt} + (TO_W+1)'(1)) >= {1'b0, toLen};

  always_comb begin
    strb = '0;
    strb.drop = !rxEn;
    if (tick) begin
      case (state)
        ST_DATA: strb.shiftEn = 1'b1;
        ST_PAR:  strb.parChk  = 1'b1;
        ST_HUNT: strb.flush   = isMark && pktOpen && toHit;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_ARM;
      prevT   <= 1'b0;
      runCnt  <= '0;
      bitCnt  <= '0;
      toCnt   <= '0;
      pktOpen <= 1'b0;
    end else begin
      prevT <= rxTiming;
      if (!rxEn) begin
        state   <= ST_ARM;
        runCnt  <= '0;
        bitCnt  <= '0;
        toCnt   <= '0;
        pktOpen <= 1'b0;
      end else if (tick) begin
        case (state)
          ST_ARM: begin
            if (!isMark) runCnt <= '0;
            else if (runCnt == RUN_W'(ARM_RUN - 1)) begin
              state  <= ST_HUNT;
              runCnt <= '0;
            end else runCnt <= runCnt + 1'b1;
          end
          ST_HUNT: begin
            if (!isMark) begin
              state  <= ST_DATA;
              bitCnt <= '0;
            end else if (pktOpen) begin
              if (toHit) begin
                pktOpen <= 1'b0;
                toCnt   <= '0;
              end else toCnt <= toCnt + 1'b1;
            end
          end
          ST_DATA: begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == 3'd7) state <= ST_PAR;
          end
          default: begin
            state   <= ST_HUNT;
            pktOpen <= 1'b1;
            toCnt   <= '0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/rxf_dp.sv
module rxf_dp
  import rxf_pkg::*;
#(
  parameter int WORD_BYTES = 4,
  parameter int WORD_DEPTH = 4,
  parameter int LEN_DEPTH  = 4,
  parameter int LEN_W      = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  rxStrb_t                     strb,
  input  logic                        rxData,
  input  logic                        msbFirst,
  input  logic                        hiByteFirst,
  input  logic                        oddParity,
  input  logic                        parIntEn,
  input  logic                        clrOvf,
  input  logic                        clrParErr,
  input  logic                        wordRdEn,
  input  logic                        lenRdEn,
  output logic [8*WORD_BYTES-1:0]     wordData,
  output logic                        wordEmpty,
  output logic [$clog2(WORD_DEPTH):0] wordCount,
  output logic [LEN_W-1:0]            lenData,
  output logic                        lenEmpty,
  output logic                        ovfFlag,
  output logic                        parErrFlag,
  output logic                        parIrq
);
  localparam int WORD_W = 8 * WORD_BYTES;
  localparam int IDX_W  = $clog2(WORD_BYTES);

  logic [7:0]        shReg;
  logic [WORD_W-1:0] wordBuf, mergedBuf, pushData;
  logic [IDX_W-1:0]  byteIdx, lane;
  logic [LEN_W-1:0]  byteCnt;
  logic              lastLane, parExp, wordPush, wordFull, lenFull;

  assign lane      = hiByteFirst ? (IDX_W'(WORD_BYTES - 1) - byteIdx) : byteIdx;
  assign lastLane  = (byteIdx == IDX_W'(WORD_BYTES - 1));
  assign parExp    = (^shReg) ^ oddParity;
  assign mergedBuf = wordBuf | (WORD_W'(shReg) << {lane, 3'b000});
  assign wordPush  = (strb.parChk && lastLane) || (strb.flush && byteIdx != '0);
  assign pushData  = strb.flush ? wordBuf : mergedBuf;
  assign parIrq    = parErrFlag && parIntEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg      <= '0;
      wordBuf    <= '0;
      byteIdx    <= '0;
      byteCnt    <= '0;
      ovfFlag    <= 1'b0;
      parErrFlag <= 1'b0;
    end else begin
      if (strb.shiftEn)
        shReg <= msbFirst ? {shReg[6:0], rxData} : {rxData, shReg[7:1]};

      if (strb.flush || strb.drop) begin
        wordBuf <= '0;
        byteIdx <= '0;
        byteCnt <= '0;
      end else if (strb.parChk) begin
        byteCnt <= byteCnt + 1'b1;
        byteIdx <= byteIdx + 1'b1;
        wordBuf <= lastLane ? '0 : mergedBuf;
      end

      if (strb.parChk && rxData != parExp) parErrFlag <= 1'b1;
      else if (clrParErr)                  parErrFlag <= 1'b0;

      if (wordPush && wordFull) ovfFlag <= 1'b1;
      else if (clrOvf)          ovfFlag <= 1'b0;
    end
  end

  rxf_fifo #(.W(WORD_W), .DEPTH(WORD_DEPTH)) u_wordFifo (
    .clk(clk), .rstN(rstN), .push(wordPush), .pushData(pushData),
    .pop(wordRdEn), .popData(wordData), .empty(wordEmpty),
    .full(wordFull), .count(wordCount)
  );

  logic [$clog2(LEN_DEPTH):0] lenCount;
  rxf_fifo #(.W(LEN_W), .DEPTH(LEN_DEPTH)) u_lenFifo (
    .clk(clk), .rstN(rstN), .push(strb.flush), .pushData(byteCnt),
    .pop(lenRdEn), .popData(lenData), .empty(lenEmpty),
    .full(lenFull), .count(lenCount)
  );

  logic unusedLen;
  assign unusedLen = lenFull ^ (^lenCount);
endmodule

// File: rtl/framed_rx.sv
module framed_rx
  import rxf_pkg::*;
#(
  parameter int ARM_RUN    = 10,
  parameter int TO_W       = 16,
  parameter int WORD_BYTES = 4,
  parameter int WORD_DEPTH = 4,
  parameter int LEN_DEPTH  = 4,
  parameter int LEN_W      = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        rxEn,
  input  logic                        markLevel,
  input  logic                        clkPol,
  input  logic                        msbFirst,
  input  logic                        hiByteFirst,
  input  logic                        oddParity,
  input  logic                        parIntEn,
  input  logic [TO_W-1:0]             toLen,
  input  logic                        rxTiming,
  input  logic                        rxData,
  input  logic                        wordRdEn,
  output logic [8*WORD_BYTES-1:0]     wordData,
  output logic                        wordEmpty,
  output logic [$clog2(WORD_DEPTH):0] wordCount,
  input  logic                        lenRdEn,
  output logic [LEN_W-1:0]            lenData,
  output logic                        lenEmpty,
  input  logic                        clrOvf,
  output logic                        ovfFlag,
  input  logic                        clrParErr,
  output logic                        parErrFlag,
  output logic                        parIrq
);
  rxStrb_t strb;

  rxf_ctrl #(.ARM_RUN(ARM_RUN), .TO_W(TO_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxEn(rxEn), .markLevel(markLevel),
    .clkPol(clkPol), .rxTiming(rxTiming), .rxData(rxData),
    .toLen(toLen), .strb(strb)
  );

  rxf_dp #(.WORD_BYTES(WORD_BYTES), .WORD_DEPTH(WORD_DEPTH),
           .LEN_DEPTH(LEN_DEPTH), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rxData(rxData),
    .msbFirst(msbFirst), .hiByteFirst(hiByteFirst), .oddParity(oddParity),
    .parIntEn(parIntEn), .clrOvf(clrOvf), .clrParErr(clrParErr),
    .wordRdEn(wordRdEn), .lenRdEn(lenRdEn), .wordData(wordData),
    .wordEmpty(wordEmpty), .wordCount(wordCount), .lenData(lenData),
    .lenEmpty(lenEmpty), .ovfFlag(ovfFlag), .parErrFlag(parErrFlag),
    .parIrq(parIrq)
  );
endmodule

// File: rtl/framed_rx_chk.sv
module framed_rx_chk
  import rxf_pkg::*;
#(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rstN,
  input logic          rxEn,
  input logic          clrOvf,
  input logic          clrParErr,
  input logic          ovfFlag,
  input logic          parErrFlag,
  input logic          wordEmpty,
  input logic [CW-1:0] wordCount,
  input logic          lenEmpty,
  input rxStrb_t       strb
);
  assert_empty_count_R9: assert property (@(posedge clk) disable iff (!rstN)
    wordEmpty |-> (wordCount == '0));

  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !clrOvf) |=> ovfFlag);

  assert_parerr_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (parErrFlag && !clrParErr) |=> parErrFlag);

  assert_flush_len_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> !lenEmpty);

  assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !rxEn |-> !(strb.shiftEn || strb.parChk || strb.flush));
endmodule

bind framed_rx framed_rx_chk #(.CW($clog2(WORD_DEPTH) + 1)) u_chk (.*);

// File: tb/tb_framed_rx.sv
`timescale 1ns/1ps
module tb_framed_rx;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxEn = 0, markLevel = 0, clkPol = 0, msbFirst = 0, hiByteFirst = 0;
  logic oddParity = 0, parIntEn = 0, rxTiming = 0, rxData = 0;
  logic wordRdEn = 0, lenRdEn = 0, clrOvf = 0, clrParErr = 0;
  logic [15:0] toLen = 16'd5;
  logic [31:0] wordData;
  logic [2:0]  wordCount;
  logic [15:0] lenData;
  logic wordEmpty, lenEmpty, ovfFlag, parErrFlag, parIrq;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  framed_rx dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    rxData = b;
    rxTiming = clkPol;
    repeat (2) @(negedge clk);
    rxTiming = ~clkPol;
    repeat (2) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) sendBit(markLevel);
  endtask

  function automatic logic parOf(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  task automatic sendByte(input logic [7:0] d, input logic par);
    sendBit(~markLevel);
    for (int i = 0; i < 8; i++) sendBit(d[i]);
    sendBit(par);
  endtask

  task automatic popWord();
    wordRdEn = 1; @(negedge clk); wordRdEn = 0; @(negedge clk);
  endtask

  task automatic popLen();
    lenRdEn = 1; @(negedge clk); lenRdEn = 0; @(negedge clk);
  endtask

  task automatic restart();
    rxEn = 0; @(negedge clk); @(negedge clk);
    rxEn = 1;
    idle(10);
  endtask

  // {cfgMsb, hiByteFirst, oddParity, nBytes[2:0], bytes (sent LSB-first, byte0 first), expected word}
  localparam logic [69:0] VEC [5] = '{
    {1'b0, 1'b0, 1'b0, 3'd4, 32'h44332211, 32'h44332211},
    {1'b0, 1'b1, 1'b0, 3'd4, 32'h44332211, 32'h11223344},
    {1'b1, 1'b0, 1'b0, 3'd4, 32'hF0800201, 32'h0F014080},
    {1'b0, 1'b0, 1'b1, 3'd3, 32'h00FF5AA5, 32'h00FF5AA5},
    {1'b0, 1'b1, 1'b0, 3'd1, 32'h0000007E, 32'h7E000000}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 wordEmpty", 32'(wordEmpty), 1);
    check("R1 lenEmpty", 32'(lenEmpty), 1);
    check("R1 wordCount", 32'(wordCount), 0);
    check("R1 ovfFlag", 32'(ovfFlag), 0);
    check("R1 parErr/parIrq", {30'd0, parErrFlag, parIrq}, 0);

    // R2 nine marking samples do not arm; all-ones frame must be ignored
    rxEn = 1;
    idle(9);
    sendByte(8'hFF, 1'b0);
    idle(5);
    check("R2 no word after short run", 32'(wordCount), 0);
    check("R2 no packet after short run", 32'(lenEmpty), 1);
    idle(5);
    sendByte(8'h3C, parOf(8'h3C, 1'b0));
    idle(5);
    check("R2 armed byte stored", wordData, 32'h0000003C);
    check("R2 armed packet length", 32'(lenData), 1);
    popWord(); popLen();

    // vector table: R4 bit order, R5 parity sense, R6 byte order, R8 length
    for (int v = 0; v < 5; v++) begin
      msbFirst    = VEC[v][69];
      hiByteFirst = VEC[v][68];
      oddParity   = VEC[v][67];
      restart();
      for (int k = 0; k < int'(VEC[v][66:64]); k++)
        sendByte(VEC[v][32 + 8*k +: 8], parOf(VEC[v][32 + 8*k +: 8], oddParity));
      idle(5);
      check($sformatf("R6/R4 vector %0d word", v), wordData, VEC[v][31:0]);
      check($sformatf("R8 vector %0d length", v), 32'(lenData), 32'(VEC[v][66:64]));
      check($sformatf("R5 vector %0d no parity error", v), 32'(parErrFlag), 0);
      popWord(); popLen();
    end
    msbFirst = 0; hiByteFirst = 0; oddParity = 0;
    restart();

    // R7 timeout boundary: N-1 idle continues, N idle closes
    sendByte(8'h12, parOf(8'h12, 1'b0));
    idle(4);
    check("R7 still open after N-1 idle", 32'(lenEmpty), 1);
    sendByte(8'h34, parOf(8'h34, 1'b0));
    idle(4);
    check("R7 open after second gap", 32'(lenEmpty), 1);
    idle(1);
    check("R7 closed on N-th idle", 32'(lenEmpty), 0);
    check("R7 one packet of two bytes", 32'(lenData), 2);
    check("R8 partial word zero-filled", wordData, 32'h00003412);
    popWord(); popLen();

    // R5 parity error, interrupt and clear
    parIntEn = 1;
    sendByte(8'h55, ~parOf(8'h55, 1'b0));
    idle(5);
    check("R5 parity error latched", 32'(parErrFlag), 1);
    check("R5 parity interrupt", 32'(parIrq), 1);
    check("R5 bad-parity byte stored", wordData, 32'h00000055);
    clrParErr = 1; @(negedge clk); clrParErr = 0; @(negedge clk);
    check("R5 parity error cleared", {30'd0, parErrFlag, parIrq}, 0);
    popWord(); popLen();

    // R10 / R9 overflow with twenty back-to-back bytes
    for (int b = 0; b < 20; b++) sendByte(8'(b), parOf(8'(b), 1'b0));
    idle(5);
    check("R9 word count at full", 32'(wordCount), 4);
    check("R10 overflow latched", 32'(ovfFlag), 1);
    check("R10 oldest word kept", wordData, 32'h03020100);
    check("R8 long packet length", 32'(lenData), 20);
    clrOvf = 1; @(negedge clk); clrOvf = 0; @(negedge clk);
    check("R10 overflow cleared", 32'(ovfFlag), 0);
    for (int w = 0; w < 4; w++) popWord();
    check("R9 drained", {30'd0, wordEmpty, 1'b0} | 32'(wordCount), 2);
    popLen();

    // R3 falling-edge sampling
    rxEn = 0; @(negedge clk);
    clkPol = 1;
    rxTiming = 1; @(negedge clk);
    restart();
    sendByte(8'hC3, parOf(8'hC3, 1'b0));
    idle(5);
    check("R3 falling-edge byte", wordData, 32'h000000C3);
    popWord(); popLen();
    rxEn = 0; @(negedge clk);
    clkPol = 0;
    rxTiming = 0; @(negedge clk);

    // R4 inverted marking level (start bit 0)
    markLevel = 1;
    rxData = 1;
    restart();
    sendByte(8'h0F, parOf(8'h0F, 1'b0));
    idle(5);
    check("R4 inverted marking byte", wordData, 32'h0000000F);
    check("R4 inverted marking length", 32'(lenData), 1);
    popWord(); popLen();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule